// File: doc/BRIEF.md
# Rotating Line Wear-Leveling Remapper

This block sits between a page write queue and a phase-change storage array. Each page holds sixteen lines, and some lines are written far more often than others. The block shifts every line of a page by one fixed offset, so that these hot spots are spread over the physical positions. The offset is kept per physical page in a small table. A new offset is taken from an internal 16-bit linear feedback shift register whenever the page is reallocated after a fault.

Line addresses on the write side are logical. The block rotates them forward: physical = (logical + rotate) mod 16. Lines coming back from the array are physical, and the block rotates them backward so that the requester gets the logical order back. Each path is a registered adder or subtractor with a latency of one cycle. Before any page is allocated, every page has offset zero and lines keep their natural order.

Top module: `wl_remap`

## Requirements
- R1: After reset all three output valids are low, all output data fields are zero, and every page has rotate 0, so a line keeps its own index on both paths.
- R2: A write request (wr_vld_i high) produces wr_vld_o one cycle later, with wr_page_o equal to the page and wr_line_o = (wr_line_i + rotate of that page) mod 16.
- R3: A read request (rd_vld_i high) produces rd_vld_o one cycle later, with rd_page_o equal to the page and rd_line_o = (rd_line_i − rotate of that page) mod 16.
- R4: The mappings wrap at 16. For example, with rotate 1, logical line 15 maps to physical line 0, and physical line 0 maps back to logical line 15.
- R5: An allocation (alloc_vld_i high) draws the rotate value from the low 4 bits of the current 16-bit LFSR state. The state then shifts left by one, with bit 0 set to the XOR of state bits 15, 13, 12 and 10. The seed after reset is 0xACE1. The drawn value appears on alloc_rot_o, with alloc_vld_o high, one cycle later, and it is stored for alloc_page_i.
- R6: A page's rotate does not change until that same page is allocated again. Allocations of other pages do not affect it.
- R7: When an allocation and a write or read of the same page arrive in the same cycle, the access uses the newly drawn value.
- R8: Each output valid is high exactly in the cycle after its input valid was high. When it is low, the output page and line hold their last values.
- R9: The LFSR advances only on allocation cycles, so idle cycles do not change the next drawn value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld_i | input | 1 | Page allocation request |
| alloc_page_i | input | 6 | Physical page being allocated |
| alloc_vld_o | output | 1 | Allocation completed |
| alloc_rot_o | output | 4 | Rotate value drawn for the allocation |
| wr_vld_i | input | 1 | Write line request |
| wr_page_i | input | 6 | Write page |
| wr_line_i | input | 4 | Logical line index |
| wr_vld_o | output | 1 | Mapped write valid |
| wr_page_o | output | 6 | Mapped write page |
| wr_line_o | output | 4 | Physical line index |
| rd_vld_i | input | 1 | Read line return |
| rd_page_i | input | 6 | Read page |
| rd_line_i | input | 4 | Physical line index from the array |
| rd_vld_o | output | 1 | Realigned read valid |
| rd_page_o | output | 6 | Realigned read page |
| rd_line_o | output | 4 | Logical line index |

## Verification
All three results are due exactly one cycle after their request. This covers the mapped write line, the realigned read line and the drawn rotate. A table update made by an allocation is visible to an access in the same cycle through the bypass, and from the next cycle on through storage.

The bench drives inputs on the falling edge. On the following falling edge it compares the outputs with the expectations computed when those inputs were applied. It keeps its own LFSR and rotate table, which it updates at the moment of issue. This keeps the model in step with the design's single register stage.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [0:0] {
    XL_FWD = 1'b0,
    XL_INV = 1'b1
  } xl_dir_e;
endpackage

// File: rtl/wl_lfsr.sv
module wl_lfsr #(
  parameter int               W     = 16,
  parameter logic [W-1:0]     SEED  = 16'hACE1,
  parameter logic [W-1:0]     TAPS  = 16'hB400,
  parameter int               OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [OUT_W-1:0] draw_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = state_q;
    if (adv_i) state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign draw_o = state_q[OUT_W-1:0];

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(state_q));
  a_r5_adv_moves: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> state_q != $past(state_q));
  a_r5_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/wl_rot_table.sv
module wl_rot_table #(
  parameter int NUM_PAGES = 64,
  parameter int ROT_W     = 4,
  localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] wpage_i,
  input  logic [ROT_W-1:0]  wrot_i,
  input  logic [PAGE_W-1:0] ra0_i,
  output logic [ROT_W-1:0]  rrot0_o,
  input  logic [PAGE_W-1:0] ra1_i,
  output logic [ROT_W-1:0]  rrot1_o
);
  logic [ROT_W-1:0] mem_q [NUM_PAGES];
  logic [ROT_W-1:0] mem_d [NUM_PAGES];

  always_comb begin
    for (int i = 0; i < NUM_PAGES; i++) mem_d[i] = mem_q[i];
    if (we_i) mem_d[wpage_i] = wrot_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PAGES; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NUM_PAGES; i++) mem_q[i] <= mem_d[i];
    end
  end

  // same-cycle allocation wins over stored value
  assign rrot0_o = (we_i && (wpage_i == ra0_i)) ? wrot_i : mem_q[ra0_i];
  assign rrot1_o = (we_i && (wpage_i == ra1_i)) ? wrot_i : mem_q[ra1_i];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_chk
    a_r6_entry_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && (wpage_i == PAGE_W'(g))) |=> $stable(mem_q[g]));
  end
endmodule

// File: rtl/wl_line_xlate.sv
module wl_line_xlate
  import wl_pkg::*;
#(
  parameter int      PAGE_W = 6,
  parameter int      LINE_W = 4,
  parameter xl_dir_e DIR    = XL_FWD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] rot_i,
  output logic              vld_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [LINE_W-1:0] line_o
);
  logic [LINE_W-1:0] mapped;
  logic              vld_q;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [LINE_W-1:0] line_q, line_d;

  if (DIR == XL_FWD) begin : g_fwd
    assign mapped = line_i + rot_i;
  end else begin : g_inv
    assign mapped = line_i - rot_i;
  end

  always_comb begin
    page_d = page_q;
    line_d = line_q;
    if (vld_i) begin
      page_d = page_i;
      line_d = mapped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      page_q <= '0;
      line_q <= '0;
    end else begin
      vld_q  <= vld_i;
      page_q <= page_d;
      line_q <= line_d;
    end
  end

  assign vld_o  = vld_q;
  assign page_o = page_q;
  assign line_o = line_q;

  a_r8_vld_latency: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o);
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ($stable(page_o) && $stable(line_o)));
  a_r1_zero_rot_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && rot_i == '0) |=> line_o == $past(line_i));
endmodule

// File: rtl/wl_remap.sv
module wl_remap
  import wl_pkg::*;
#(
  parameter int          NUM_PAGES = 64,
  parameter int          LINES     = 16,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  localparam int         PAGE_W    = $clog2(NUM_PAGES),
  localparam int         LINE_W    = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_vld_i,
  input  logic [PAGE_W-1:0] alloc_page_i,
  output logic              alloc_vld_o,
  output logic [LINE_W-1:0] alloc_rot_o,
  input  logic              wr_vld_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic [LINE_W-1:0] wr_line_i,
  output logic              wr_vld_o,
  output logic [PAGE_W-1:0] wr_page_o,
  output logic [LINE_W-1:0] wr_line_o,
  input  logic              rd_vld_i,
  input  logic [PAGE_W-1:0] rd_page_i,
  input  logic [LINE_W-1:0] rd_line_i,
  output logic              rd_vld_o,
  output logic [PAGE_W-1:0] rd_page_o,
  output logic [LINE_W-1:0] rd_line_o
);
  logic [LINE_W-1:0] draw;
  logic [LINE_W-1:0] wr_rot, rd_rot;
  logic              av_q;
  logic [LINE_W-1:0] ar_q, ar_d;

  wl_lfsr #(
    .W(LFSR_W), .SEED(LFSR_SEED[LFSR_W-1:0]),
    .TAPS(LFSR_TAPS[LFSR_W-1:0]), .OUT_W(LINE_W)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv_i(alloc_vld_i), .draw_o(draw)
  );

  wl_rot_table #(.NUM_PAGES(NUM_PAGES), .ROT_W(LINE_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .we_i(alloc_vld_i), .wpage_i(alloc_page_i), .wrot_i(draw),
    .ra0_i(wr_page_i), .rrot0_o(wr_rot),
    .ra1_i(rd_page_i), .rrot1_o(rd_rot)
  );

  wl_line_xlate #(.PAGE_W(PAGE_W), .LINE_W(LINE_W), .DIR(XL_FWD)) u_fwd (
    .clk(clk), .rst_n(rst_n),
    .vld_i(wr_vld_i), .page_i(wr_page_i), .line_i(wr_line_i), .rot_i(wr_rot),
    .vld_o(wr_vld_o), .page_o(wr_page_o), .line_o(wr_line_o)
  );

  wl_line_xlate #(.PAGE_W(PAGE_W), .LINE_W(LINE_W), .DIR(XL_INV)) u_inv (
    .clk(clk), .rst_n(rst_n),
    .vld_i(rd_vld_i), .page_i(rd_page_i), .line_i(rd_line_i), .rot_i(rd_rot),
    .vld_o(rd_vld_o), .page_o(rd_page_o), .line_o(rd_line_o)
  );

  always_comb begin
    ar_d = ar_q;
    if (alloc_vld_i) ar_d = draw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      av_q <= 1'b0;
      ar_q <= '0;
    end else begin
      av_q <= alloc_vld_i;
      ar_q <= ar_d;
    end
  end

  assign alloc_vld_o = av_q;
  assign alloc_rot_o = ar_q;

  // R7: a collided write/read must carry the offset reported for the allocation
  a_r7_wr_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld_i && wr_vld_i && alloc_page_i == wr_page_i)
      |=> LINE_W'(wr_line_o - $past(wr_line_i)) == alloc_rot_o);
  a_r7_rd_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld_i && rd_vld_i && alloc_page_i == rd_page_i)
      |=> LINE_W'($past(rd_line_i) - rd_line_o) == alloc_rot_o);
  a_r5_alloc_vld: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld_i |=> alloc_vld_o);
endmodule

// File: tb/sim_wl_remap.sv
module sim_wl_remap;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       alloc_vld_i;
  logic [5:0] alloc_page_i;
  logic       alloc_vld_o;
  logic [3:0] alloc_rot_o;
  logic       wr_vld_i;
  logic [5:0] wr_page_i;
  logic [3:0] wr_line_i;
  logic       wr_vld_o;
  logic [5:0] wr_page_o;
  logic [3:0] wr_line_o;
  logic       rd_vld_i;
  logic [5:0] rd_page_i;
  logic [3:0] rd_line_i;
  logic       rd_vld_o;
  logic [5:0] rd_page_o;
  logic [3:0] rd_line_o;

  always #2 clk = ~clk;

  wl_remap u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int     rot_m [64];
  logic [15:0] lfsr_m;
  bit     e_av, e_wv, e_rv;
  int     e_ar, e_wp, e_wl, e_rp, e_rl;
  string  t_a, t_w, t_r;
  string  force_tag = "";

  function automatic logic [15:0] lfsr_nxt(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_outs();
    chk("R8", int'(alloc_vld_o), int'(e_av), "alloc_vld");
    chk(e_av ? t_a : "R8", int'(alloc_rot_o), e_ar, "alloc_rot");
    chk("R8", int'(wr_vld_o), int'(e_wv), "wr_vld");
    chk(e_wv ? t_w : "R8", int'(wr_page_o), e_wp, "wr_page");
    chk(e_wv ? t_w : "R8", int'(wr_line_o), e_wl, "wr_line");
    chk("R8", int'(rd_vld_o), int'(e_rv), "rd_vld");
    chk(e_rv ? t_r : "R8", int'(rd_page_o), e_rp, "rd_page");
    chk(e_rv ? t_r : "R8", int'(rd_line_o), e_rl, "rd_line");
  endtask

  task automatic step(bit av, int ap, bit wv, int wp, int wl, bit rv, int rp, int rl);
    int draw, rot;
    @(negedge clk);
    check_outs();
    alloc_vld_i = av; alloc_page_i = 6'(ap);
    wr_vld_i = wv; wr_page_i = 6'(wp); wr_line_i = 4'(wl);
    rd_vld_i = rv; rd_page_i = 6'(rp); rd_line_i = 4'(rl);
    draw = int'(lfsr_m[3:0]);
    e_wv = wv;
    if (wv) begin
      rot  = (av && ap == wp) ? draw : rot_m[wp];
      e_wp = wp;
      e_wl = (wl + rot) % 16;
      t_w  = (av && ap == wp) ? "R7" : (rot == 0) ? "R1" : (wl + rot >= 16) ? "R4" : "R2";
      if (force_tag != "") t_w = force_tag;
    end
    e_rv = rv;
    if (rv) begin
      rot  = (av && ap == rp) ? draw : rot_m[rp];
      e_rp = rp;
      e_rl = (rl - rot + 16) % 16;
      t_r  = (av && ap == rp) ? "R7" : (rot == 0) ? "R1" : (rl < rot) ? "R4" : "R3";
      if (force_tag != "") t_r = force_tag;
    end
    e_av = av;
    if (av) begin
      e_ar = draw;
      t_a  = "R5/R9";
      rot_m[ap] = draw;
      lfsr_m = lfsr_nxt(lfsr_m);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 64; i++) rot_m[i] = 0;
    lfsr_m = 16'hACE1;
    e_av = 0; e_wv = 0; e_rv = 0;
    e_ar = 0; e_wp = 0; e_wl = 0; e_rp = 0; e_rl = 0;
    alloc_vld_i = 0; alloc_page_i = 0;
    wr_vld_i = 0; wr_page_i = 0; wr_line_i = 0;
    rd_vld_i = 0; rd_page_i = 0; rd_line_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state of outputs
    chk("R1", int'(wr_vld_o), 0, "wr_vld reset");
    chk("R1", int'(rd_vld_o), 0, "rd_vld reset");
    chk("R1", int'(alloc_vld_o), 0, "alloc_vld reset");
    chk("R1", int'(wr_line_o), 0, "wr_line reset");
    rst_n = 1;

    // R1: natural order before any allocation
    for (int l = 0; l < 16; l++) step(0, 0, 1, 3, l, 1, 40, 15 - l);

    // R5/R4: allocate page 5 then sweep all lines both ways
    step(1, 5, 0, 0, 0, 0, 0, 0);
    for (int l = 0; l < 16; l++) step(0, 0, 1, 5, l, 1, 5, l);

    // R7: allocation colliding with write and read of the same page
    step(1, 7, 1, 7, 15, 1, 7, 0);
    step(1, 7, 1, 7, 3, 0, 0, 0);
    step(1, 8, 0, 0, 0, 1, 8, 9);

    // R6: page 9 offset survives allocations of other pages and idle time
    step(1, 9, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 2, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    force_tag = "R6";
    step(1, 3, 1, 9, 0, 1, 9, 0);
    step(0, 0, 1, 9, 15, 1, 9, 15);
    force_tag = "";

    // R9: idle gap, then allocation draws the next sequence value
    repeat (5) step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 10, 0, 0, 0, 0, 0, 0);

    // constrained random mix over a few pages to force collisions
    for (int k = 0; k < 4000; k++) begin
      bit av, wv, rv;
      av = ($urandom % 4) == 0;
      wv = ($urandom % 3) != 0;
      rv = ($urandom % 3) != 0;
      step(av, $urandom % 8, wv, $urandom % 8, $urandom % 16,
           rv, $urandom % 8, $urandom % 16);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule